// File: doc/BRIEF.md
# Periodic Wake-Up Timer with Duty-Cycled Receiver Enable

This block counts a slow tick of about one millisecond. It raises a wake-up flag once a programmed interval has passed. The interval is coded as an 8-bit mantissa and a 5-bit exponent, and it lasts mantissa·2^exponent ticks plus one extra tick of fixed latency. The timer is one-shot. Software re-arms it by taking the enable low and then high again. The flag stays set until a status-read pulse clears it.

A second, free-running function shares the same mantissa as its frame length in ticks. While duty-cycle mode is on, the receiver-enable output is high for the first 2·D+1 ticks of each frame. The output stays high beyond that window for as long as the signal-quality input reports a good signal. Frames restart by themselves and are not affected by the one-shot timer or its flag.

Top module: `wake_duty_timer`

## Requirements
- R1: A rising edge of `timerEn` with `mant` nonzero arms the timer. `wakeFlag` rises on the clock edge that samples the (mant·2^expo + 1)-th `tick` pulse after arming, and not before.
- R2: An exponent above parameter MAX_EXP (default 29) is used as MAX_EXP.
- R3: After it expires, the timer stays idle and cannot set the flag again until `timerEn` goes low and then high.
- R4: `wakeFlag` stays high until `statusClr` is sampled high, and reads low on the following cycle. If an expiry and a clear happen in the same cycle, the flag stays set.
- R5: Taking `timerEn` low while the count is running cancels it, and no flag results.
- R6: Arming with `mant` = 0 does nothing, so the flag is never set.
- R7: While `dutyEn` is high and `mant` is nonzero, a frame phase starts at 0 when `dutyEn` rises, advances by one on each `tick`, and wraps from mant−1 to 0. `rxEn` is high exactly when phase < 2·dutyD+1, which means it is always high when 2·dutyD+1 ≥ mant.
- R8: If `goodSig` is high while `rxEn` is high, `rxEn` stays high past the window until the cycle after `goodSig` goes low. `goodSig` on its own never turns `rxEn` on.
- R9: With `dutyEn` low or `mant` = 0, `rxEn` is low and the phase is held at 0.
- R10: After reset, `wakeFlag` and `rxEn` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per slow time unit |
| mant | input | 8 | Period mantissa M; also the frame length |
| expo | input | 5 | Period exponent R |
| dutyD | input | 7 | On-window parameter D (2·D+1 ticks) |
| timerEn | input | 1 | Timer enable; a rising edge arms the timer |
| dutyEn | input | 1 | Duty-cycle mode enable |
| goodSig | input | 1 | Signal-quality indication |
| statusClr | input | 1 | Status-read pulse that clears the flag |
| wakeFlag | output | 1 | Sticky expiry flag |
| rxEn | output | 1 | Receiver enable |

## Verification
The timer is swept over a grid of mantissas and exponents, with every tick before expiry checked, so that an off-by-one in the latency tick or in the shift is caught. Exponents above a reduced MAX_EXP are included to show the clamp at work. Separate runs check disarming, re-expiry without re-arming, a zero mantissa, and a clear that lands on the expiry cycle. The duty-cycle output is compared tick by tick against an arithmetic phase model over several frame lengths and window sizes, including windows that cover the whole frame. Dedicated sequences show that a good signal stretches a window that is already on, and that it cannot open one that is off.

// File: rtl/wkt_pkg.sv
package wkt_pkg;
  typedef enum logic { T_IDLE = 1'b0, T_RUN = 1'b1 } tState_e;

  typedef struct packed {
    logic loadCnt;
    logic decCnt;
    logic frameClr;
    logic frameStep;
  } ctlStrobe_t;
endpackage

// File: rtl/wkt_datapath.sv
module wkt_datapath
  import wkt_pkg::*;
#(
  parameter int MANT_W  = 8,
  parameter int EXP_W   = 5,
  parameter int DUTY_W  = 7,
  parameter int MAX_EXP = 29
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [MANT_W-1:0] mant,
  input  logic [EXP_W-1:0]  expo,
  input  logic [DUTY_W-1:0] dutyD,
  output logic              lastTick,
  output logic              onWin
);
  localparam int CNT_W = MANT_W + MAX_EXP + 1;
  localparam int CMP_W = (MANT_W > DUTY_W + 1) ? MANT_W : DUTY_W + 1;
  localparam logic [EXP_W-1:0] EXP_LIM = EXP_W'(MAX_EXP);

  logic [CNT_W-1:0]  cntQ;
  logic [CNT_W-1:0]  loadVal;
  logic [EXP_W-1:0]  expEff;
  logic [MANT_W-1:0] phaseQ;
  logic [CMP_W-1:0]  phaseExt;
  logic [CMP_W-1:0]  winLen;

  // Exponent clamp, then the shifted mantissa plus one latency tick
  always_comb begin
    expEff  = (int'(expo) > MAX_EXP) ? EXP_LIM : expo;
    loadVal = (CNT_W'(mant) << expEff) + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 cntQ <= '0;
    else if (strobe.loadCnt)   cntQ <= loadVal;
    else if (strobe.decCnt)    cntQ <= cntQ - CNT_W'(1);
  end

  assign lastTick = (cntQ == CNT_W'(1));

  // Frame phase counter for duty-cycle mode
  always_ff @(posedge clk) begin
    if (!rstN)                 phaseQ <= '0;
    else if (strobe.frameClr)  phaseQ <= '0;
    else if (phaseQ >= mant)   phaseQ <= '0;
    else if (strobe.frameStep) phaseQ <= (phaseQ == mant - MANT_W'(1)) ? '0 : phaseQ + MANT_W'(1);
  end

  always_comb begin
    phaseExt = CMP_W'(phaseQ);
    winLen   = CMP_W'({dutyD, 1'b1});
    onWin    = phaseExt < winLen;
  end

  // R1
  cntNoUnder_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decCnt |-> (cntQ != '0));

  // R7
  phaseRange_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.frameClr && $stable(mant) && phaseQ < mant) |=> (phaseQ < mant));
endmodule

// File: rtl/wkt_control.sv
module wkt_control
  import wkt_pkg::*;
#(
  parameter int MANT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [MANT_W-1:0] mant,
  input  logic              timerEn,
  input  logic              dutyEn,
  input  logic              goodSig,
  input  logic              statusClr,
  input  logic              lastTick,
  input  logic              onWin,
  output ctlStrobe_t        strobe,
  output logic              wakeFlag,
  output logic              rxEn
);
  tState_e stateQ;
  logic    enPrev;
  logic    holdQ;
  logic    mantNz;
  logic    armNow;
  logic    expire;
  logic    dutyActive;

  always_comb begin
    mantNz           = (mant != '0);
    armNow           = timerEn && !enPrev && mantNz;
    strobe.loadCnt   = armNow;
    strobe.decCnt    = (stateQ == T_RUN) && timerEn && tick && !armNow;
    expire           = strobe.decCnt && lastTick;
    dutyActive       = dutyEn && mantNz;
    strobe.frameClr  = !dutyActive;
    strobe.frameStep = dutyActive && tick;
    rxEn             = dutyActive && (onWin || holdQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= T_IDLE;
      enPrev   <= 1'b0;
      wakeFlag <= 1'b0;
      holdQ    <= 1'b0;
    end else begin
      enPrev <= timerEn;
      if (armNow)                                       stateQ <= T_RUN;
      else if (stateQ == T_RUN && (!timerEn || expire)) stateQ <= T_IDLE;
      if (expire)         wakeFlag <= 1'b1;
      else if (statusClr) wakeFlag <= 1'b0;
      holdQ <= rxEn && goodSig;
    end
  end

  // R4
  flagHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wakeFlag && !statusClr) |=> wakeFlag);

  // R4
  flagClr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusClr && !expire) |=> !wakeFlag);

  // R3
  oneShot_chk: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> (stateQ == T_IDLE));

  // R5
  noWakeOff_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!timerEn && !wakeFlag) |=> !wakeFlag);

  // R9
  rxOff_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dutyEn || !mantNz) |-> !rxEn);
endmodule

// File: rtl/wake_duty_timer.sv
module wake_duty_timer
  import wkt_pkg::*;
#(
  parameter int MANT_W  = 8,
  parameter int EXP_W   = 5,
  parameter int DUTY_W  = 7,
  parameter int MAX_EXP = 29
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [MANT_W-1:0] mant,
  input  logic [EXP_W-1:0]  expo,
  input  logic [DUTY_W-1:0] dutyD,
  input  logic              timerEn,
  input  logic              dutyEn,
  input  logic              goodSig,
  input  logic              statusClr,
  output logic              wakeFlag,
  output logic              rxEn
);
  ctlStrobe_t strobe;
  logic       lastTick;
  logic       onWin;

  wkt_control #(.MANT_W(MANT_W)) uCtl (
    .clk(clk), .rstN(rstN), .tick(tick), .mant(mant),
    .timerEn(timerEn), .dutyEn(dutyEn), .goodSig(goodSig),
    .statusClr(statusClr), .lastTick(lastTick), .onWin(onWin),
    .strobe(strobe), .wakeFlag(wakeFlag), .rxEn(rxEn)
  );

  wkt_datapath #(.MANT_W(MANT_W), .EXP_W(EXP_W), .DUTY_W(DUTY_W), .MAX_EXP(MAX_EXP)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mant(mant), .expo(expo),
    .dutyD(dutyD), .lastTick(lastTick), .onWin(onWin)
  );

  // R10
  resetQuiet_chk: assert property (@(posedge clk) $past(!rstN) |-> (!wakeFlag));
endmodule

// File: tb/wake_duty_timer_test.sv
`timescale 1ns/1ps
module wake_duty_timer_test;
  localparam int MAXE = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] mant = '0;
  logic [4:0] expo = '0;
  logic [6:0] dutyD = '0;
  logic       timerEn = 1'b0;
  logic       dutyEn = 1'b0;
  logic       goodSig = 1'b0;
  logic       statusClr = 1'b0;
  logic       wakeFlag;
  logic       rxEn;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  wake_duty_timer #(.MAX_EXP(MAXE)) uut (
    .clk(clk), .rstN(rstN), .tick(tick), .mant(mant), .expo(expo),
    .dutyD(dutyD), .timerEn(timerEn), .dutyEn(dutyEn), .goodSig(goodSig),
    .statusClr(statusClr), .wakeFlag(wakeFlag), .rxEn(rxEn)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tickOnce();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic clearFlag();
    @(negedge clk) statusClr = 1'b1;
    @(negedge clk) statusClr = 1'b0;
  endtask

  task automatic arm(input int m, input int r);
    @(negedge clk) timerEn = 1'b0;
    clearFlag();
    mant = 8'(m);
    expo = 5'(r);
    @(negedge clk) timerEn = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  function automatic int period(input int m, input int r);
    int e = (r > MAXE) ? MAXE : r;
    return m * (1 << e) + 1;
  endfunction

  task automatic runWake(input int m, input int r, input string req);
    int n = period(m, r);
    int early = 0;
    arm(m, r);
    for (int i = 1; i < n; i++) begin
      tickOnce();
      if (wakeFlag && early == 0) early = i;
    end
    chk(early == 0, req, early, 0);
    tickOnce();
    chk(wakeFlag == 1'b1, req, wakeFlag, 1);
  endtask

  task automatic runDuty(input int m, input int d);
    int ph = 0;
    int bad = 0;
    @(negedge clk) dutyEn = 1'b0;
    goodSig = 1'b0;
    mant = 8'(m);
    dutyD = 7'(d);
    @(negedge clk) dutyEn = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 2 * m + 1; i++) begin
      // R7: on when phase < 2D+1
      chk(rxEn == (ph < 2 * d + 1), "R7", rxEn, int'(ph < 2 * d + 1));
      tickOnce();
      ph = (ph + 1) % m;
    end
    if (bad != 0) chk(1'b0, "R7", bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(wakeFlag == 1'b0, "R10", wakeFlag, 0);
    chk(rxEn == 1'b0, "R10", rxEn, 0);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);

    // R1 period sweep
    for (int m = 1; m <= 7; m += 2)
      for (int r = 0; r <= 3; r++)
        runWake(m, r, "R1");
    runWake(2, 4, "R1");
    // R2 exponent clamp
    runWake(3, 6, "R2");
    runWake(1, 31, "R2");

    // R4 sticky then cleared
    repeat (10) @(negedge clk);
    chk(wakeFlag == 1'b1, "R4", wakeFlag, 1);
    clearFlag();
    chk(wakeFlag == 1'b0, "R4", wakeFlag, 0);

    // R3 no re-expiry without re-arming
    runWake(2, 1, "R3");
    clearFlag();
    repeat (period(2, 1) + 4) tickOnce();
    chk(wakeFlag == 1'b0, "R3", wakeFlag, 0);

    // R5 disarm mid-count
    arm(3, 2);
    repeat (6) tickOnce();
    @(negedge clk) timerEn = 1'b0;
    repeat (period(3, 2)) tickOnce();
    chk(wakeFlag == 1'b0, "R5", wakeFlag, 0);

    // R6 zero mantissa never arms
    arm(0, 2);
    repeat (20) tickOnce();
    chk(wakeFlag == 1'b0, "R6", wakeFlag, 0);

    // R4 clear coinciding with expiry: set wins
    arm(1, 1);
    repeat (period(1, 1) - 1) tickOnce();
    @(negedge clk) begin tick = 1'b1; statusClr = 1'b1; end
    @(negedge clk) begin tick = 1'b0; statusClr = 1'b0; end
    chk(wakeFlag == 1'b1, "R4", wakeFlag, 1);
    @(negedge clk) timerEn = 1'b0;
    clearFlag();

    // R7 duty sweep, including always-on windows
    for (int m = 3; m <= 8; m += 5)
      for (int d = 0; d <= 4; d++)
        runDuty(m, d);
    runDuty(5, 1);
    runDuty(4, 2);

    // R9 duty off and zero mantissa
    @(negedge clk) dutyEn = 1'b0;
    repeat (3) tickOnce();
    chk(rxEn == 1'b0, "R9", rxEn, 0);
    mant = 8'd0;
    @(negedge clk) dutyEn = 1'b1;
    repeat (3) tickOnce();
    chk(rxEn == 1'b0, "R9", rxEn, 0);

    // R8 stretch: M=8, D=0 gives a one-tick window
    @(negedge clk) dutyEn = 1'b0;
    mant = 8'd8;
    dutyD = 7'd0;
    @(negedge clk) dutyEn = 1'b1;
    goodSig = 1'b1;
    @(negedge clk);
    chk(rxEn == 1'b1, "R8", rxEn, 1);
    repeat (3) tickOnce();
    chk(rxEn == 1'b1, "R8", rxEn, 1);
    goodSig = 1'b0;
    @(negedge clk);
    chk(rxEn == 1'b0, "R8", rxEn, 0);
    tickOnce();
    goodSig = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(rxEn == 1'b0, "R8", rxEn, 0);
    goodSig = 1'b0;
    repeat (4) tickOnce();
    chk(rxEn == 1'b1, "R8", rxEn, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule